// File: doc/BRIEF.md
# Dual-Subevent Timed Event Sequencer

This block turns a trigger into timed activity on one event output. Once armed, the first qualifying trigger starts a programmable wait; when it expires, subevent 0 is issued. In single mode that drives a pulse of programmable length. In dual mode a second programmable wait follows subevent 0, and subevent 1 ends it. The output is high from subevent 0 to subevent 1, which gives a PWM-style level. Waits are measured either in system clock cycles or in microsecond ticks from an external strobe.

The trigger is either a pulse on a plain trigger input, or a selected edge of a digital input. For digital triggers the free-running timestamp is captured at detection. Firmware programs three registers through a write port. A read strobe latches a status word holding the armed and active flags, sticky issued flags and an event counter. Two interrupt outputs pulse when the subevents are issued. The sequencer can stop after one sequence or re-arm after every sequence.

Top module: `evs_top`

## Requirements
- R1: While the enable bit (control bit 0) is 0, triggers are ignored and the event output stays 0. Writing enable 0 aborts any sequence and clears the counter and the armed, active0 and active1 flags. Writing enable 1 when it was 0 arms the block.
- R2: Control bit 1 selects the delay unit: 0 counts clock cycles; 1 counts cycles with `us_tick` high. In tick mode a subevent is issued on the cycle after the tick that completes its delay.
- R3: In clock mode with delay 0 value D, an accepted trigger sampled at edge T issues subevent 0 at edge T+1+D, where the event output rises.
- R4: In single mode (control bit 2 = 0) the output stays high for L clock cycles, where L is control bits 15:8; L = 0 acts as 1.
- R5: In dual mode (control bit 2 = 1) subevent 1 is issued D1+1 cycles after subevent 0 (clock mode), and the output falls there; it is high for D1+1 cycles.
- R6: With control bit 3 = 0 the block disarms after a sequence and ignores later triggers until enable is written 0 then 1; with bit 3 = 1 it re-arms as the sequence ends.
- R7: `irq0` (enabled by control bit 4) and `irq1` (by bit 5) each pulse for one cycle at the edge where their subevent is issued.
- R8: A read strobe latches the status word: bit 0 armed, bit 1 waiting for subevent 0, bit 2 waiting for subevent 1, bit 3 subevent 0 issued, bit 4 subevent 1 issued. Bits 3 and 4 are sticky and clear on a read, except when their subevent is issued in the read cycle.
- R9: Status bits 15:8 count accepted triggers since enable and wrap from 255 to 0.
- R10: Control bit 7 = 1 takes triggers from `dig_in` edges: bit 6 = 1 rising, 0 falling. The other edge is ignored. `ts_cap` holds the `ts_in` value sampled at the accepting edge.
- R11: A trigger that arrives while a sequence is in progress is ignored: it neither restarts a delay nor counts.
- R12: Write addresses: 0 control, 1 delay 0, 2 delay 1. The delays are full 32-bit values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| sts_rd | input | 1 | Status read strobe |
| sts_rdata | output | 32 | Status word latched by the last read |
| trig_in | input | 1 | Trigger pulse from the external source decoder |
| dig_in | input | 1 | Digital event input |
| us_tick | input | 1 | One-cycle microsecond strobe |
| ts_in | input | 32 | Free-running timestamp |
| ts_cap | output | 32 | Timestamp at the last accepted digital event |
| ev_out | output | 1 | Event output: pulse or PWM level |
| irq0 | output | 1 | Subevent 0 interrupt pulse |
| irq1 | output | 1 | Subevent 1 interrupt pulse |

## Verification
A status read strobe can land on the same edge that issues subevent 0. In that case the read must return the old, clear issued flag, and the flag must remain set for the next read rather than being wiped by the clear-on-read. The bench triggers with a known delay and places the read strobe on exactly the issue edge. It then expects three results: the active flag with a clear issued flag, then a set flag, then a clear flag on the following read. A second overlap, a retrigger during a running dual sequence, is judged by an unchanged output width and an event count of one.

// File: rtl/evs_pkg.sv
package evs_pkg;
  localparam int PLEN_W = 8;

  typedef enum logic [2:0] {
    S_IDLE, S_ARMED, S_WAIT0, S_WAIT1, S_PULSE
  } seq_state_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_DLY0 = 2'd1;
  localparam logic [1:0] ADDR_DLY1 = 2'd2;

  typedef struct packed {
    logic [PLEN_W-1:0] plen;     // 15:8 single-mode pulse length
    logic              src_dig;  // 7 trigger from digital edge
    logic              rising;   // 6 edge polarity
    logic              irq1_en;  // 5
    logic              irq0_en;  // 4
    logic              rpt;      // 3 re-arm after sequence
    logic              dual;     // 2 two subevents
    logic              us_unit;  // 1 delays in microsecond ticks
    logic              en;       // 0
  } ctrl_t;
endpackage

// File: rtl/evs_trig.sv
module evs_trig #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            src_dig,
  input  logic            rising,
  input  logic            trig_in,
  input  logic            dig_in,
  input  logic            accept,
  input  logic [TS_W-1:0] ts_in,
  output logic            hit,
  output logic [TS_W-1:0] ts_cap
);
  logic dig_q;
  logic edge_rise, edge_fall, edge_hit;

  always_ff @(posedge clk) begin
    if (rst) dig_q <= 1'b0;
    else     dig_q <= dig_in;
  end

  assign edge_rise = dig_in & ~dig_q;
  assign edge_fall = ~dig_in & dig_q;
  assign edge_hit  = rising ? edge_rise : edge_fall;
  assign hit       = en & (src_dig ? edge_hit : trig_in);

  always_ff @(posedge clk) begin
    if (rst)                    ts_cap <= '0;
    else if (accept && src_dig) ts_cap <= ts_in;
  end

  // R10: capture follows the accepted digital event
  a_r10_ts_capture: assert property (@(posedge clk) disable iff (rst)
    (accept && src_dig) |=> (ts_cap == $past(ts_in)));
endmodule

// File: rtl/evs_delay.sv
module evs_delay #(
  parameter int DLY_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DLY_W-1:0] load_val,
  input  logic             us_unit,
  input  logic             us_tick,
  output logic             zero
);
  logic [DLY_W-1:0] cnt;
  logic             step;

  assign step = us_unit ? us_tick : 1'b1;

  always_ff @(posedge clk) begin
    if (rst)                           cnt <= '0;
    else if (load)                     cnt <= load_val;
    else if ((cnt != '0) && step)      cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // R2: in tick mode the count only moves on a tick
  a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
    (!load && us_unit && !us_tick) |=> $stable(cnt));
endmodule

// File: rtl/evs_status.sv
module evs_status #(
  parameter int CNT_W = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clr_cnt,
  input  logic        inc,
  input  logic        armed,
  input  logic        act0,
  input  logic        act1,
  input  logic        set0,
  input  logic        set1,
  input  logic        rd,
  output logic [31:0] rdata
);
  localparam int CNT_LSB = 8;

  logic [CNT_W-1:0] cnt;
  logic             iss0, iss1;
  logic [31:0]      word;

  always_ff @(posedge clk) begin
    if (rst) begin
      iss0 <= 1'b0;
      iss1 <= 1'b0;
    end else begin
      iss0 <= set0 | (iss0 & ~rd);
      iss1 <= set1 | (iss1 & ~rd);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_cnt) cnt <= '0;
    else if (inc)       cnt <= cnt + 1'b1;
  end

  always_comb begin
    word = '0;
    word[0] = armed;
    word[1] = act0;
    word[2] = act1;
    word[3] = iss0;
    word[4] = iss1;
    word[CNT_LSB +: CNT_W] = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= word;
  end

  // R8: issue always leaves the flag set, a read without issue clears it
  a_r8_sticky_set: assert property (@(posedge clk) disable iff (rst)
    set0 |=> iss0);
  a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd && !set1) |=> !iss1);
  // R9: counter wraps to zero
  a_r9_wrap: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr_cnt && (cnt == {CNT_W{1'b1}})) |=> (cnt == '0));
endmodule

// File: rtl/evs_top.sv
module evs_top
  import evs_pkg::*;
#(
  parameter int DLY_W = 32,
  parameter int TS_W  = 32,
  parameter int CNT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_addr,
  input  logic [31:0]     cfg_wdata,
  input  logic            sts_rd,
  output logic [31:0]     sts_rdata,
  input  logic            trig_in,
  input  logic            dig_in,
  input  logic            us_tick,
  input  logic [TS_W-1:0] ts_in,
  output logic [TS_W-1:0] ts_cap,
  output logic            ev_out,
  output logic            irq0,
  output logic            irq1
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t             ctrl, new_ctrl;
  logic [DLY_W-1:0]  dly0, dly1;
  seq_state_t        st;
  logic [PLEN_W-1:0] pcnt;

  logic ctrl_wr, dis, arm_now;
  logic hit, accept, issue0, issue1, dz;
  logic ld;
  logic [DLY_W-1:0] ld_val;
  seq_state_t done_st;

  assign ctrl_wr  = cfg_we && (cfg_addr == ADDR_CTRL);
  assign new_ctrl = ctrl_t'(cfg_wdata[CTRL_W-1:0]);
  assign dis      = ctrl_wr && !new_ctrl.en;
  assign arm_now  = ctrl_wr && new_ctrl.en && !ctrl.en;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
      dly0 <= '0;
      dly1 <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        ADDR_CTRL: ctrl <= new_ctrl;
        ADDR_DLY0: dly0 <= cfg_wdata[DLY_W-1:0];
        ADDR_DLY1: dly1 <= cfg_wdata[DLY_W-1:0];
        default:   ;
      endcase
    end
  end

  evs_trig #(.TS_W(TS_W)) u_trig (
    .clk     (clk),
    .rst     (rst),
    .en      (ctrl.en),
    .src_dig (ctrl.src_dig),
    .rising  (ctrl.rising),
    .trig_in (trig_in),
    .dig_in  (dig_in),
    .accept  (accept),
    .ts_in   (ts_in),
    .hit     (hit),
    .ts_cap  (ts_cap)
  );

  assign accept  = (st == S_ARMED) && hit && !dis;
  assign issue0  = (st == S_WAIT0) && dz && !dis;
  assign issue1  = (st == S_WAIT1) && dz && !dis;
  assign ld      = accept || (issue0 && ctrl.dual);
  assign ld_val  = accept ? dly0 : dly1;
  assign done_st = ctrl.rpt ? S_ARMED : S_IDLE;

  evs_delay #(.DLY_W(DLY_W)) u_delay (
    .clk      (clk),
    .rst      (rst),
    .load     (ld),
    .load_val (ld_val),
    .us_unit  (ctrl.us_unit),
    .us_tick  (us_tick),
    .zero     (dz)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      ev_out <= 1'b0;
      pcnt   <= '0;
      irq0   <= 1'b0;
      irq1   <= 1'b0;
    end else begin
      irq0 <= issue0 && ctrl.irq0_en;
      irq1 <= issue1 && ctrl.irq1_en;
      if (dis) begin
        st     <= S_IDLE;
        ev_out <= 1'b0;
      end else if (arm_now) begin
        st <= S_ARMED;
      end else begin
        case (st)
          S_ARMED: if (accept) st <= S_WAIT0;
          S_WAIT0: if (issue0) begin
            ev_out <= 1'b1;
            if (ctrl.dual) st <= S_WAIT1;
            else begin
              st   <= S_PULSE;
              pcnt <= (ctrl.plen == '0) ? '0 : ctrl.plen - 1'b1;
            end
          end
          S_WAIT1: if (issue1) begin
            ev_out <= 1'b0;
            st     <= done_st;
          end
          S_PULSE: if (pcnt == '0) begin
            ev_out <= 1'b0;
            st     <= done_st;
          end else begin
            pcnt <= pcnt - 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  evs_status #(.CNT_W(CNT_W)) u_status (
    .clk     (clk),
    .rst     (rst),
    .clr_cnt (dis),
    .inc     (accept),
    .armed   (st == S_ARMED),
    .act0    (st == S_WAIT0),
    .act1    (st == S_WAIT1),
    .set0    (issue0),
    .set1    (issue1),
    .rd      (sts_rd),
    .rdata   (sts_rdata)
  );

  // R1: disabled block sits idle with its output low
  a_r1_disabled_idle: assert property (@(posedge clk) disable iff (rst)
    !ctrl.en |-> (st == S_IDLE && !ev_out));
  // R4: pulse phase always drives the output high
  a_r4_pulse_high: assert property (@(posedge clk) disable iff (rst)
    (st == S_PULSE) |-> ev_out);
  // R5: subevent 1 drops the output
  a_r5_low_after_sub1: assert property (@(posedge clk) disable iff (rst)
    issue1 |=> !ev_out);
  // R7: the two interrupts never pulse together
  a_r7_irq_apart: assert property (@(posedge clk) disable iff (rst)
    $onehot0({irq0, irq1}));
  // R11: a trigger mid-sequence leaves the state alone
  a_r11_no_restart: assert property (@(posedge clk) disable iff (rst)
    ((st == S_WAIT0 || st == S_WAIT1) && hit && !dz && !ctrl_wr) |=> $stable(st));
endmodule

// File: tb/tb_evs_top.sv
module tb_evs_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        sts_rd = 1'b0;
  logic [31:0] sts_rdata;
  logic        trig_in = 1'b0;
  logic        dig_in = 1'b0;
  logic        us_tick = 1'b0;
  logic [31:0] ts_in = 32'h1000;
  logic [31:0] ts_cap;
  logic        ev_out, irq0, irq1;
  logic [1:0]  tph = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  always_ff @(posedge clk) begin
    tph     <= tph + 1'b1;
    us_tick <= (tph == 2'd3);
    ts_in   <= ts_in + 1;
  end

  evs_top dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .sts_rd(sts_rd), .sts_rdata(sts_rdata),
    .trig_in(trig_in), .dig_in(dig_in), .us_tick(us_tick), .ts_in(ts_in),
    .ts_cap(ts_cap), .ev_out(ev_out), .irq0(irq0), .irq1(irq1)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(bit en, bit us, bit dual, bit rpt, bit i0,
                                     bit i1, bit rising, bit dig, logic [7:0] plen);
    return {16'b0, plen, dig, rising, i1, i0, rpt, dual, us, en};
  endfunction

  function automatic int exp_width(bit dual, int d1, int plen);
    if (dual) return d1 + 1;
    return (plen == 0) ? 1 : plen;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(output logic [31:0] v);
    sts_rd = 1'b1;
    @(negedge clk);
    sts_rd = 1'b0;
    v = sts_rdata;
  endtask

  task automatic pulse_trig();
    trig_in = 1'b1;
    @(negedge clk);
    trig_in = 1'b0;
  endtask

  task automatic measure(output int lat, output int wid, output int tk0,
                         output int tk1, output logic i0, output logic i1);
    logic tk;
    lat = 0; wid = 0; tk0 = 0; tk1 = 0;
    while (!ev_out && lat < 3000) begin
      tk = us_tick; @(negedge clk); lat++;
      if (!ev_out) tk0 += int'(tk);
    end
    i0 = irq0;
    while (ev_out && wid < 3000) begin
      tk = us_tick; @(negedge clk); wid++;
      if (ev_out) tk1 += int'(tk);
    end
    i1 = irq1;
  endtask

  task automatic quiet(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      seen += int'(ev_out);
    end
    chk(req, seen, 0);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] s, ets;
    int lat, wid, tk0, tk1;
    logic i0, i1;
    void'($urandom(32'd4242));

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    chk("R1 reset ev_out", ev_out, 0);
    chk("R7 reset irq", {irq0, irq1}, 0);
    rd(s);
    chk("R8 reset status", s, 0);

    // R1: disabled block ignores triggers
    wr(2'd1, 32'd0);
    pulse_trig();
    quiet(6, "R1 disabled trigger");
    rd(s);
    chk("R1 disabled count", s[15:8], 0);

    // R6 one-time
    wr(2'd1, 32'd2);
    wr(2'd0, mk(1,0,0,0,1,0,1,0,8'd3));
    pulse_trig();
    measure(lat, wid, tk0, tk1, i0, i1);
    chk("R3 single latency", lat, 3);
    chk("R4 single width", wid, 3);
    rd(s);
    chk("R6 one-time disarmed", s[0], 0);
    chk("R9 count one", s[15:8], 1);
    pulse_trig();
    quiet(10, "R6 one-time ignores trigger");
    rd(s);
    chk("R6 count unchanged", s[15:8], 1);

    // R11 retrigger in dual repeat sequence
    wr(2'd0, 32'd0);
    wr(2'd1, 32'd3);
    wr(2'd2, 32'd10);
    wr(2'd0, mk(1,0,1,1,1,1,1,0,8'd0));
    pulse_trig();
    lat = 0;
    while (!ev_out && lat < 100) begin @(negedge clk); lat++; end
    chk("R5 dual latency", lat, 4);
    repeat (2) @(negedge clk);
    pulse_trig();
    wid = 3;
    while (ev_out && wid < 100) begin @(negedge clk); wid++; end
    chk("R11 width unchanged", wid, 11);
    rd(s);
    chk("R11 single count", s[15:8], 1);
    chk("R6 repeat re-armed", s[0], 1);
    chk("R8 issued1 sticky", s[4], 1);

    // R8 read on the issue edge
    wr(2'd0, 32'd0);
    wr(2'd1, 32'd4);
    wr(2'd0, mk(1,0,0,1,0,0,1,0,8'd1));
    rd(s);
    pulse_trig();
    repeat (4) @(negedge clk);
    rd(s);
    chk("R8 collision active0", s[1], 1);
    chk("R8 collision old issued0", s[3], 0);
    chk("R3 output at issue", ev_out, 1);
    rd(s);
    chk("R8 issued0 kept", s[3], 1);
    rd(s);
    chk("R8 issued0 cleared", s[3], 0);

    // R9 wrap
    wr(2'd0, 32'd0);
    wr(2'd1, 32'd0);
    wr(2'd0, mk(1,0,0,1,0,0,1,0,8'd1));
    for (int i = 1; i <= 257; i++) begin
      pulse_trig();
      repeat (3) @(negedge clk);
      if (i == 255 || i == 256 || i == 257) begin
        rd(s);
        chk("R9 wrap count", s[15:8], i % 256);
      end
    end

    // R10 digital edges with timestamp
    wr(2'd0, 32'd0);
    wr(2'd1, 32'd1);
    wr(2'd0, mk(1,0,0,1,0,0,1,1,8'd1));
    dig_in = 1'b1; ets = ts_in;
    @(negedge clk);
    measure(lat, wid, tk0, tk1, i0, i1);
    chk("R10 rising latency", lat, 2);
    chk("R10 rising timestamp", ts_cap, ets);
    dig_in = 1'b0;
    quiet(6, "R10 falling ignored");
    wr(2'd0, mk(1,0,0,1,0,0,0,1,8'd1));
    dig_in = 1'b1;
    quiet(4, "R10 rising ignored");
    dig_in = 1'b0; ets = ts_in;
    @(negedge clk);
    measure(lat, wid, tk0, tk1, i0, i1);
    chk("R10 falling latency", lat, 2);
    chk("R10 falling timestamp", ts_cap, ets);

    // R12 wide delay, then R1 abort
    wr(2'd0, 32'd0);
    wr(2'd1, 32'h8000_0003);
    wr(2'd0, mk(1,0,0,1,0,0,1,0,8'd1));
    pulse_trig();
    quiet(40, "R12 wide delay holds");
    rd(s);
    chk("R12 still waiting", s[1], 1);
    wr(2'd0, 32'd0);
    rd(s);
    chk("R1 abort clears flags", s[2:0], 0);
    chk("R1 abort clears count", s[15:8], 0);

    // random sequences
    for (int it = 0; it < 40; it++) begin
      int d0, d1, pl;
      bit du, us, e0, e1;
      d0 = int'($urandom_range(0, 12));
      d1 = int'($urandom_range(0, 12));
      pl = int'($urandom_range(0, 5));
      du = 1'($urandom_range(0, 1));
      us = 1'($urandom_range(0, 1));
      e0 = 1'($urandom_range(0, 1));
      e1 = 1'($urandom_range(0, 1));
      wr(2'd0, 32'd0);
      wr(2'd1, 32'(d0));
      wr(2'd2, 32'(d1));
      wr(2'd0, mk(1,us,du,1,e0,e1,1,0,8'(pl)));
      pulse_trig();
      measure(lat, wid, tk0, tk1, i0, i1);
      if (us) chk("R2 ticks to subevent 0", tk0, d0);
      else    chk("R3 latency", lat, d0 + 1);
      if (du && us) chk("R2 ticks to subevent 1", tk1, d1);
      else chk(du ? "R5 dual width" : "R4 pulse width", wid, exp_width(du, d1, pl));
      chk("R7 irq0", i0, e0);
      chk("R7 irq1", i1, du && e1);
      rd(s);
      chk("R6 re-armed", s[0], 1);
      chk("R9 count", s[15:8], 1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule